// File: doc/BRIEF.md
# Two-Byte-Fetch Hardwired Instruction Sequencer

This block is the control half of a small processor whose instructions are 16 bits wide while its memory returns one byte per access. A timing counter walks every instruction through three steps. In the first two steps the block fetches the instruction, one byte per step and little-endian: the low byte comes from the address in the program counter, and the next byte comes from the address one higher. The PC advances after each byte. In the third step the block decodes the instruction register and raises the enables and selects that carry out the operation. Then the counter returns to the first step.

Two instruction layouts are decoded. The address-reference layout carries a mode bit, a two-bit register pick and an 8-bit address or constant. Loads and stores in this layout use either the constant (immediate) or the memory word that AR points at (direct). The conditional branch loads the PC only when the zero flag is clear. The register-to-register layout names a destination and two sources for moves, increments, decrements and additions. The datapath registers, the ALU and the memory sit outside the block. It sees only the instruction register and the zero flag, and it drives select and enable lines.

Top module: `hwc_seq_ctrl`

## Requirements
- R1: While rst_n is low, every enable is inactive (ir_load, mem_rd, mem_wr, rf_we all zero, pc_ctl/ar_ctl/sp_ctl = 0 hold) and step is 0. The first cycle after release is a low-byte fetch.
- R2: In step 0 the block drives mem_rd=1, addr_sel=0 (PC), ir_load=1, ir_hi=0 (load ir[7:0]) and pc_ctl=1 (increment).
- R3: In step 1 the block drives the same lines as in step 0, except ir_hi=1 (load ir[15:8]).
- R4: Execution takes exactly step 2. The following cycle is step 0 again, and step counts 0,1,2,0,... from reset.
- R5: Opcode ir[15:12]=0 (load) with ir[10]=1 (immediate) drives src_a=9 (instruction constant), alu_fn=0 (pass) and rf_we one-hot at bit ir[9:8] (codes 0..3 pick R1..R4).
- R6: A load with ir[10]=0 (direct) also raises mem_rd with addr_sel=1 (AR) and takes src_a=8 (memory byte).
- R7: Opcode 1 (store) with ir[10]=0 drives mem_wr=1, addr_sel=1 and src_a = register ir[9:8] with pass. With ir[10]=1 it changes nothing.
- R8: Opcodes 2 move, 3 add, 4 increment and 5 decrement use alu_fn 0,1,2,3. src_a is the code in ir[7:4], and add also takes src_b from ir[3:0]; a source code of 7 or above reads as 7 (zero). The destination ir[11:8] codes 0..3 write R1..R4, 4 loads PC, 5 loads AR, 6 loads SP (ctl value 3), and 7..15 write nothing.
- R9: Opcode 6 drives pc_ctl=3 (load) with src_a=9 and pass.
- R10: Opcode 7 loads the PC as opcode 6 does when zero_flag is 0. When zero_flag is 1 it holds the PC.
- R11: Opcodes 8..15 raise no enable in step 2.
- R12: rf_we has at most one bit set, and mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| zero_flag | input | 1 | ALU zero flag from the last result written |
| step | output | 3 | Current timing step |
| ir_load | output | 1 | Load one instruction-register half from memory |
| ir_hi | output | 1 | Half select: 0 low byte, 1 high byte |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write of the ALU result |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 AR |
| pc_ctl | output | 2 | PC action: 0 hold, 1 increment, 3 load ALU result |
| ar_ctl | output | 2 | AR action, same coding |
| sp_ctl | output | 2 | SP action, same coding |
| rf_we | output | 4 | Write enables for R1..R4 |
| src_a | output | 4 | ALU operand A: 0-3 R1-R4, 4 PC, 5 AR, 6 SP, 7 zero, 8 memory byte, 9 constant |
| src_b | output | 4 | ALU operand B, codes 0-7 as for src_a |
| alu_fn | output | 2 | 0 pass A, 1 A+B, 2 A+1, 3 A-1 |

## Verification
A wrong step count shows at once: in the cycle it goes wrong, the block either loads the instruction register when it should execute, or executes from a half-filled register. The next fetch then reads from a shifted PC, so every later instruction and every end result is corrupted. Errors in the field slicing or in the destination decode show in the same execute cycle as a wrong enable bit or select code. The reference model compares every cycle, so a fault is named in the cycle where it appears. Two small programs run on a behavioural datapath. Their final register and memory contents show any fault that only a cycle-by-cycle comparison would otherwise reveal, such as a branch taken on the wrong flag value.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  localparam int NREG = 4;

  typedef enum logic [1:0] {
    RC_HOLD = 2'd0,
    RC_INC  = 2'd1,
    RC_DEC  = 2'd2,
    RC_LOAD = 2'd3
  } regctl_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_INC  = 2'd2,
    ALU_DEC  = 2'd3
  } alu_e;

  typedef enum logic [3:0] {
    SRC_R1   = 4'd0,
    SRC_R2   = 4'd1,
    SRC_R3   = 4'd2,
    SRC_R4   = 4'd3,
    SRC_PC   = 4'd4,
    SRC_AR   = 4'd5,
    SRC_SP   = 4'd6,
    SRC_ZERO = 4'd7,
    SRC_MEM  = 4'd8,
    SRC_IMM  = 4'd9
  } src_e;

  localparam logic [3:0] OP_LD  = 4'd0;
  localparam logic [3:0] OP_ST  = 4'd1;
  localparam logic [3:0] OP_MOV = 4'd2;
  localparam logic [3:0] OP_ADD = 4'd3;
  localparam logic [3:0] OP_INC = 4'd4;
  localparam logic [3:0] OP_DEC = 4'd5;
  localparam logic [3:0] OP_BRA = 4'd6;
  localparam logic [3:0] OP_BNE = 4'd7;

  localparam logic [3:0] DST_PC = 4'd4;
  localparam logic [3:0] DST_AR = 4'd5;
  localparam logic [3:0] DST_SP = 4'd6;

  typedef struct packed {
    logic            ir_load;
    logic            ir_hi;
    logic            mem_rd;
    logic            mem_wr;
    logic            addr_ar;
    regctl_e         pc;
    regctl_e         ar;
    regctl_e         sp;
    logic [NREG-1:0] rf_we;
    src_e            src_a;
    src_e            src_b;
    alu_e            alu;
  } ctrl_t;

  function automatic ctrl_t f_idle();
    ctrl_t c;
    c.ir_load = 1'b0;
    c.ir_hi   = 1'b0;
    c.mem_rd  = 1'b0;
    c.mem_wr  = 1'b0;
    c.addr_ar = 1'b0;
    c.pc      = RC_HOLD;
    c.ar      = RC_HOLD;
    c.sp      = RC_HOLD;
    c.rf_we   = '0;
    c.src_a   = SRC_ZERO;
    c.src_b   = SRC_ZERO;
    c.alu     = ALU_PASS;
    return c;
  endfunction

  // 4-bit register field to operand source; codes above SP read zero
  function automatic src_e f_src_of_code(input logic [3:0] code);
    if (code < 4'd7) return src_e'(code);
    return SRC_ZERO;
  endfunction

  function automatic logic [NREG-1:0] f_onehot(input logic [1:0] idx);
    return NREG'(1) << idx;
  endfunction

  function automatic alu_e f_alu_of_op(input logic [3:0] op);
    case (op)
      OP_ADD:  return ALU_ADD;
      OP_INC:  return ALU_INC;
      OP_DEC:  return ALU_DEC;
      default: return ALU_PASS;
    endcase
  endfunction

  // route a register-to-register result to its destination
  function automatic ctrl_t f_route_dest(input ctrl_t c, input logic [3:0] dst);
    ctrl_t r;
    r = c;
    if (dst < 4'd4)       r.rf_we = f_onehot(dst[1:0]);
    else if (dst == DST_PC) r.pc  = RC_LOAD;
    else if (dst == DST_AR) r.ar  = RC_LOAD;
    else if (dst == DST_SP) r.sp  = RC_LOAD;
    return r;
  endfunction

endpackage

// File: rtl/hwc_step_timer.sv
module hwc_step_timer #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_i,
  output logic [STEP_W-1:0] step_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_o <= '0;
    else if (last_i) step_o <= '0;
    else             step_o <= step_o + 1'b1;
  end

endmodule

// File: rtl/hwc_ir_fields.sv
module hwc_ir_fields #(
  parameter int IW = 16
) (
  input  logic [IW-1:0] ir_i,
  output logic [3:0]    op_o,
  output logic          mode_imm_o,
  output logic [1:0]    rsel_o,
  output logic [3:0]    dst_o,
  output logic [3:0]    src1_o,
  output logic [3:0]    src2_o
);

  localparam int OP_LSB   = IW - 4;
  localparam int DST_LSB  = IW - 8;
  localparam int MODE_BIT = IW - 6;
  localparam int RSEL_LSB = IW - 8;
  localparam int S1_LSB   = IW - 12;

  assign op_o       = ir_i[OP_LSB +: 4];
  assign mode_imm_o = ir_i[MODE_BIT];
  assign rsel_o     = ir_i[RSEL_LSB +: 2];
  assign dst_o      = ir_i[DST_LSB +: 4];
  assign src1_o     = ir_i[S1_LSB +: 4];
  assign src2_o     = ir_i[3:0];

endmodule

// File: rtl/hwc_exec_decode.sv
module hwc_exec_decode
  import hwc_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       mode_imm_i,
  input  logic [1:0] rsel_i,
  input  logic [3:0] dst_i,
  input  logic [3:0] src1_i,
  input  logic [3:0] src2_i,
  input  logic       zero_i,
  output ctrl_t      ctrl_o
);

  logic bne_taken;
  assign bne_taken = (op_i == OP_BNE) && !zero_i;

  always_comb begin
    ctrl_o = f_idle();
    case (op_i)
      OP_LD: begin
        ctrl_o.rf_we = f_onehot(rsel_i);
        ctrl_o.alu   = ALU_PASS;
        if (mode_imm_i) begin
          ctrl_o.src_a = SRC_IMM;
        end else begin
          ctrl_o.src_a   = SRC_MEM;
          ctrl_o.mem_rd  = 1'b1;
          ctrl_o.addr_ar = 1'b1;
        end
      end
      OP_ST: begin
        if (!mode_imm_i) begin
          ctrl_o.mem_wr  = 1'b1;
          ctrl_o.addr_ar = 1'b1;
          ctrl_o.src_a   = src_e'({2'b00, rsel_i});
          ctrl_o.alu     = ALU_PASS;
        end
      end
      OP_MOV, OP_ADD, OP_INC, OP_DEC: begin
        ctrl_o.src_a = f_src_of_code(src1_i);
        if (op_i == OP_ADD) ctrl_o.src_b = f_src_of_code(src2_i);
        ctrl_o.alu = f_alu_of_op(op_i);
        ctrl_o     = f_route_dest(ctrl_o, dst_i);
      end
      OP_BRA, OP_BNE: begin
        if (op_i == OP_BRA || bne_taken) begin
          ctrl_o.pc    = RC_LOAD;
          ctrl_o.src_a = SRC_IMM;
          ctrl_o.alu   = ALU_PASS;
        end
      end
      default: ctrl_o = f_idle();
    endcase
  end

endmodule

// File: rtl/hwc_seq_ctrl.sv
module hwc_seq_ctrl
  import hwc_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int IW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     ir,
  input  logic              zero_flag,
  output logic [STEP_W-1:0] step,
  output logic              ir_load,
  output logic              ir_hi,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              addr_sel,
  output logic [1:0]        pc_ctl,
  output logic [1:0]        ar_ctl,
  output logic [1:0]        sp_ctl,
  output logic [NREG-1:0]   rf_we,
  output logic [3:0]        src_a,
  output logic [3:0]        src_b,
  output logic [1:0]        alu_fn
);

  localparam logic [STEP_W-1:0] ST_FETCH_LO = STEP_W'(0);
  localparam logic [STEP_W-1:0] ST_FETCH_HI = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_EXEC     = STEP_W'(2);

  // named step events
  logic ev_fetch_lo, ev_fetch_hi, ev_exec, ev_last;
  logic [3:0] f_op, f_dst, f_s1, f_s2;
  logic [1:0] f_rsel;
  logic       f_imm;
  ctrl_t      exec_ctrl, ctrl;

  hwc_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .last_i (ev_last),
    .step_o (step)
  );

  assign ev_fetch_lo = (step == ST_FETCH_LO);
  assign ev_fetch_hi = (step == ST_FETCH_HI);
  assign ev_exec     = (step == ST_EXEC);
  // execute step, or any unused count, ends the instruction
  assign ev_last     = (step >= ST_EXEC);

  hwc_ir_fields #(.IW(IW)) u_fields (
    .ir_i       (ir),
    .op_o       (f_op),
    .mode_imm_o (f_imm),
    .rsel_o     (f_rsel),
    .dst_o      (f_dst),
    .src1_o     (f_s1),
    .src2_o     (f_s2)
  );

  hwc_exec_decode u_exec (
    .op_i       (f_op),
    .mode_imm_i (f_imm),
    .rsel_i     (f_rsel),
    .dst_i      (f_dst),
    .src1_i     (f_s1),
    .src2_i     (f_s2),
    .zero_i     (zero_flag),
    .ctrl_o     (exec_ctrl)
  );

  always_comb begin
    ctrl = f_idle();
    if (rst_n) begin
      if (ev_fetch_lo || ev_fetch_hi) begin
        ctrl.ir_load = 1'b1;
        ctrl.ir_hi   = ev_fetch_hi;
        ctrl.mem_rd  = 1'b1;
        ctrl.addr_ar = 1'b0;
        ctrl.pc      = RC_INC;
      end else if (ev_exec) begin
        ctrl = exec_ctrl;
      end
    end
  end

  assign ir_load  = ctrl.ir_load;
  assign ir_hi    = ctrl.ir_hi;
  assign mem_rd   = ctrl.mem_rd;
  assign mem_wr   = ctrl.mem_wr;
  assign addr_sel = ctrl.addr_ar;
  assign pc_ctl   = ctrl.pc;
  assign ar_ctl   = ctrl.ar;
  assign sp_ctl   = ctrl.sp;
  assign rf_we    = ctrl.rf_we;
  assign src_a    = ctrl.src_a;
  assign src_b    = ctrl.src_b;
  assign alu_fn   = ctrl.alu;

endmodule

// File: rtl/hwc_ctrl_checker.sv
module hwc_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ir,
  input logic        zero_flag,
  input logic [2:0]  step,
  input logic        ir_load,
  input logic        ir_hi,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        addr_sel,
  input logic [1:0]  pc_ctl,
  input logic [1:0]  ar_ctl,
  input logic [1:0]  sp_ctl,
  input logic [3:0]  rf_we
);

  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!ir_load && !mem_rd && !mem_wr && rf_we == 4'd0 && pc_ctl == 2'd0));

  // R2
  a_r2_fetch_from_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> (mem_rd && !addr_sel && pc_ctl == 2'd1));

  // R3
  a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_load && !ir_hi) |=> (ir_load && ir_hi));

  // R4
  a_r4_high_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_load && ir_hi) |=> !ir_load);

  // R4
  a_r4_exec_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> (ir_load && !ir_hi && step == 3'd0));

  // R7
  a_r7_store_via_ar: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> addr_sel);

  // R8
  a_r8_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rf_we != 4'd0, !ir_load && pc_ctl == 2'd3,
                ar_ctl == 2'd3, sp_ctl == 2'd3}) <= 1);

  // R10
  a_r10_no_branch_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ir_load && ir[15:12] == 4'd7 && zero_flag) |-> pc_ctl == 2'd0);

  // R11
  a_r11_high_ops_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ir_load && ir[15]) |-> (!mem_wr && !mem_rd && rf_we == 4'd0 && pc_ctl == 2'd0));

  // R12
  a_r12_rf_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rf_we));

  // R12
  a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind hwc_seq_ctrl hwc_ctrl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ir        (ir),
  .zero_flag (zero_flag),
  .step      (step),
  .ir_load   (ir_load),
  .ir_hi     (ir_hi),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .addr_sel  (addr_sel),
  .pc_ctl    (pc_ctl),
  .ar_ctl    (ar_ctl),
  .sp_ctl    (sp_ctl),
  .rf_we     (rf_we)
);

// File: tb/hwc_seq_ctrl_bench.sv
module hwc_seq_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ir = '0;
  logic        zero_flag = 1'b0;
  logic [2:0]  step;
  logic        ir_load, ir_hi, mem_rd, mem_wr, addr_sel;
  logic [1:0]  pc_ctl, ar_ctl, sp_ctl, alu_fn;
  logic [3:0]  rf_we, src_a, src_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwc_seq_ctrl u_hwc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .ir(ir), .zero_flag(zero_flag), .step(step),
    .ir_load(ir_load), .ir_hi(ir_hi), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr_sel(addr_sel), .pc_ctl(pc_ctl), .ar_ctl(ar_ctl), .sp_ctl(sp_ctl),
    .rf_we(rf_we), .src_a(src_a), .src_b(src_b), .alu_fn(alu_fn)
  );

  // behavioural datapath stand-in
  logic [7:0] mem [0:255];
  logic [7:0] rr  [0:3];
  logic [7:0] pc = 8'd0, ar = 8'd0, sp = 8'd0;
  int ph = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] opnd(input int s, input logic [7:0] rd);
    if (s < 4)  return rr[s];
    if (s == 4) return pc;
    if (s == 5) return ar;
    if (s == 6) return sp;
    if (s == 8) return rd;
    if (s == 9) return ir[7:0];
    return 8'd0;
  endfunction

  always @(posedge clk) begin
    logic [7:0] adr, rd, a, b, res;
    logic wrote;
    if (!rst_n) begin
      pc = 0; ar = 0; sp = 0; ir = '0; zero_flag = 0; ph = 0;
    end else begin
      adr = addr_sel ? ar : pc;
      rd  = mem[adr];
      a   = opnd(int'(src_a), rd);
      b   = opnd(int'(src_b), rd);
      case (alu_fn)
        2'd0: res = a;
        2'd1: res = a + b;
        2'd2: res = a + 8'd1;
        default: res = a - 8'd1;
      endcase
      wrote = 0;
      if (ir_load) begin
        if (ir_hi) ir[15:8] = rd; else ir[7:0] = rd;
      end
      if (mem_wr) mem[adr] = res;
      for (int i = 0; i < 4; i++) if (rf_we[i]) begin rr[i] = res; wrote = 1; end
      if (ar_ctl == 2'd3) begin ar = res; wrote = 1; end
      if (sp_ctl == 2'd3) begin sp = res; wrote = 1; end
      if (pc_ctl == 2'd1) pc = pc + 8'd1;
      else if (pc_ctl == 2'd3) begin pc = res; wrote = 1; end
      if (wrote) zero_flag = (res == 8'd0);
      ph = (ph == 2) ? 0 : ph + 1;
    end
  end

  // cycle-by-cycle reference of the control lines
  always @(negedge clk) begin
    int e_ld, e_hi, e_rd, e_wr, e_as, e_pc, e_ar, e_sp, e_we, e_sa, e_sb, e_alu;
    int op, d, s1, s2, rs;
    bit im;
    string tg;
    if (!rst_n) begin
      check("R1 idle enables", {ir_load, mem_rd, mem_wr, rf_we, pc_ctl, ar_ctl, sp_ctl}, 0);
      check("R1 step", step, 0);
    end else begin
      op = ir[15:12]; d = ir[11:8]; s1 = ir[7:4]; s2 = ir[3:0];
      rs = ir[9:8]; im = ir[10];
      e_ld = 0; e_hi = 0; e_rd = 0; e_wr = 0; e_as = -1; e_pc = 0; e_ar = 0;
      e_sp = 0; e_we = 0; e_sa = -1; e_sb = -1; e_alu = -1;
      if (ph < 2) begin
        tg = (ph == 0) ? "R2" : "R3";
        e_ld = 1; e_hi = ph; e_rd = 1; e_as = 0; e_pc = 1;
      end else begin
        case (op)
          0: begin
            tg = im ? "R5" : "R6";
            e_we = 1 << rs; e_alu = 0;
            if (im) e_sa = 9;
            else begin e_sa = 8; e_rd = 1; e_as = 1; end
          end
          1: begin
            tg = "R7";
            if (!im) begin e_wr = 1; e_as = 1; e_sa = rs; e_alu = 0; end
          end
          2, 3, 4, 5: begin
            tg = "R8";
            e_alu = op - 2;
            e_sa = (s1 < 7) ? s1 : 7;
            if (op == 3) e_sb = (s2 < 7) ? s2 : 7;
            if (d < 4) e_we = 1 << d;
            else if (d == 4) e_pc = 3;
            else if (d == 5) e_ar = 3;
            else if (d == 6) e_sp = 3;
          end
          6: begin tg = "R9"; e_pc = 3; e_sa = 9; e_alu = 0; end
          7: begin
            tg = "R10";
            if (!zero_flag) begin e_pc = 3; e_sa = 9; e_alu = 0; end
          end
          default: tg = "R11";
        endcase
      end
      check("R4 step", step, ph);
      check({tg, " ir_load/ir_hi"}, {ir_load, ir_hi}, {e_ld[0], e_hi[0]});
      check({tg, " mem_rd/mem_wr"}, {mem_rd, mem_wr}, {e_rd[0], e_wr[0]});
      check({tg, " pc/ar/sp ctl"}, {pc_ctl, ar_ctl, sp_ctl}, {e_pc[1:0], e_ar[1:0], e_sp[1:0]});
      check({tg, " rf_we"}, rf_we, e_we);
      if (e_as >= 0)  check({tg, " addr_sel"}, addr_sel, e_as);
      if (e_sa >= 0)  check({tg, " src_a"}, src_a, e_sa);
      if (e_sb >= 0)  check({tg, " src_b"}, src_b, e_sb);
      if (e_alu >= 0) check({tg, " alu_fn"}, alu_fn, e_alu);
      check("R12 rf_we one-hot", ($countones(rf_we) <= 1) ? 1 : 0, 1);
      check("R12 rd/wr exclusive", (mem_rd && mem_wr) ? 1 : 0, 0);
    end
  end

  task automatic put(input int adr, input logic [15:0] w);
    mem[adr] = w[7:0];
    mem[adr+1] = w[15:8];
  endtask

  task automatic start_run();
    @(posedge clk); #1 rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hC3;
    for (int i = 0; i < 4; i++) rr[i] = 8'd0;
  endtask

  task automatic release_run(input int cycles);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  initial begin
    // program 1: sum five bytes at 0xA0.. into 0xA6
    start_run();
    put(8'h00, 16'h6020);
    put(8'h20, 16'h0405); put(8'h22, 16'h0500); put(8'h24, 16'h06A0);
    put(8'h26, 16'h2520); put(8'h28, 16'h0200); put(8'h2A, 16'h3112);
    put(8'h2C, 16'h4550); put(8'h2E, 16'h5000); put(8'h30, 16'h7428);
    put(8'h32, 16'h4550); put(8'h34, 16'h1100); put(8'h36, 16'h6036);
    mem[8'hA0] = 8'h03; mem[8'hA1] = 8'h07; mem[8'hA2] = 8'h10;
    mem[8'hA3] = 8'h21; mem[8'hA4] = 8'h05;
    release_run(130);
    check("R7 stored total", mem[8'hA6], 8'h40);
    check("R8 add total R2", rr[1], 8'h40);
    check("R10 loop counter R1", rr[0], 8'h00);
    check("R6 last direct load R3", rr[2], 8'h05);
    check("R8 AR after increments", ar, 8'hA6);
    check("R9 halt loop pc", (pc >= 8'h36 && pc <= 8'h38) ? 1 : 0, 1);

    // program 2: untaken branch, SP/PC/AR destinations, ignored store and dest
    start_run();
    put(8'h00, 16'h0700); put(8'h02, 16'h7440); put(8'h04, 16'h0477);
    put(8'h06, 16'h2600); put(8'h08, 16'h0510); put(8'h0A, 16'h2510);
    put(8'h0C, 16'h1455); put(8'h0E, 16'h2700); put(8'h10, 16'h9000);
    put(8'h12, 16'h0630); put(8'h14, 16'h2420); put(8'h16, 16'h07EE);
    put(8'h30, 16'h6030);
    release_run(60);
    check("R10 not taken, R4 untouched", rr[3], 8'h00);
    check("R5 immediate R1", rr[0], 8'h77);
    check("R8 SP destination", sp, 8'h77);
    check("R8 AR destination", ar, 8'h10);
    check("R7 immediate store no write at AR", mem[8'h10], 8'h00);
    check("R7 immediate store no write at field", mem[8'h55], 8'h96);
    check("R8 dest code 7 leaves R2", rr[1], 8'h10);
    check("R8 PC destination jump", (pc >= 8'h30 && pc <= 8'h32) ? 1 : 0, 1);
    check("R11 nop leaves R3", rr[2], 8'h30);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule